// File: doc/BRIEF.md
# Serial potentiometer command processor

This block sits behind a two-wire bus receiver and turns its byte stream into register operations for a device with up to four digital potentiometers. The receiver reports a start condition, a stop condition and each received byte with a one-cycle strobe. For every byte the block decides whether it is acknowledged. It then updates the wiper counters and the nonvolatile data registers, and it presents a read byte for the receiver to shift out.

Each potentiometer has one volatile wiper counter, which drives its tap position, and four nonvolatile data registers numbered 0 to 3. A transaction has three parts. The first is an address byte, matched against a fixed device type and four strapped address pins. The second is an instruction byte. The third part is zero or more data bytes. Writes to nonvolatile storage and all register transfers keep the block busy for a fixed number of cycles. A status read can poll this busy state.

After reset, every wiper counter is loaded from data register 0 of its own potentiometer.

Top module: `pot_cmd_proc`

## Requirements
- R1: An address byte is acknowledged when bits [7:4] equal 0101 and bits [3:0] equal `addr_pins_i`. On a mismatch the byte is not acknowledged, and every byte up to the next start is ignored and not acknowledged.
- R2: The instruction byte has this layout: [7:5] opcode, [4:3] data register select, [2:1] potentiometer select, [0] auxiliary bit. When the block is not busy it acknowledges this byte for every opcode.
- R3: Opcode 101 writes the wiper counter. The next byte's bits [5:0] load the selected wiper, the byte is acknowledged, and later bytes are not acknowledged. Wipers change only in the cycle after a received byte, or at power-up.
- R4: Opcode 100 reads the wiper counter. `rd_data_o` shows {00, wiper} in the cycle after the instruction byte.
- R5: Opcode 111 writes the selected data register with bits [5:0] of the next byte. Opcode 110 returns {00, data register} on `rd_data_o` in the cycle after the instruction byte. A data write leaves the wiper unchanged.
- R6: Opcode 010 copies the selected data register into the selected wiper. Opcode 011 copies the selected wiper into the selected data register.
- R7: Opcode 001 is a global transfer over all potentiometers using the register select. With aux 0 every wiper loads from its data register. With aux 1 every data register is loaded from its wiper.
- R8: Opcode 000 with aux 0 starts stepping. Each following byte is acknowledged and moves the selected wiper up by one if bit 7 is 1, or down by one if bit 7 is 0. The wiper stays at 63 when stepped up and at 0 when stepped down.
- R9: Opcode 000 with aux 1 is a status read. `rd_data_o` = {0000000, busy} in the cycle after the instruction byte, and this byte is acknowledged even while busy.
- R10: A data write, a transfer or a global transfer raises `busy_o` for exactly BUSY_CYCLES cycles, starting in the cycle after the completing byte. While busy, an instruction byte other than a status read is not acknowledged and has no effect.
- R11: During reset every wiper reads 0 and `busy_o` and `ack_o` are 0. In the cycle after reset is released each wiper equals R0_INIT, the reset value of data register 0. The reset value of data registers 1 to 3 is 0.
- R12: A stop returns the block to idle. Bytes received after a stop and before the next start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start condition strobe |
| stop_i | input | 1 | Stop condition strobe |
| byte_valid_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| addr_pins_i | input | 4 | Strapped device address |
| ack_o | output | 1 | One-cycle pulse: previous byte acknowledged |
| rd_data_o | output | 8 | Byte for the receiver to send on reads |
| busy_o | output | 1 | Nonvolatile write or transfer in progress |
| wiper_o | output | N_POT*WIPER_W | Wiper positions, potentiometer p at [p*WIPER_W +: WIPER_W] |

## Verification
The acknowledge, the read byte and every register or wiper effect of a byte are due one cycle after the clock edge that samples `byte_valid_i`. The bench drives each byte on a falling edge for one cycle and reads the results on the next falling edge, which falls inside that result cycle. The busy window starts in the same cycle. The bench then counts the falling edges on which `busy_o` is high and compares that count with BUSY_CYCLES. The power-up load is checked one falling edge after reset is released.

// File: rtl/pot_pkg.sv
package pot_pkg;
  localparam int N_DREG = 4;  // fixed by the 2-bit register select field

  typedef enum logic [2:0] {
    OP_STEP   = 3'b000,
    OP_GLOBAL = 3'b001,
    OP_D2W    = 3'b010,
    OP_W2D    = 3'b011,
    OP_RD_W   = 3'b100,
    OP_WR_W   = 3'b101,
    OP_RD_D   = 3'b110,
    OP_WR_D   = 3'b111
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_INSTR, ST_DATA} st_e;

  typedef struct packed {
    logic       wr_w;
    logic       wr_d;
    logic       step;
    logic       up;
    logic       d2w;
    logic       w2d;
    logic       all;
    logic [1:0] pot;
    logic [1:0] rsel;
  } cmd_t;
endpackage

// File: rtl/pot_busy_timer.sv
module pot_busy_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pot_regfile.sv
module pot_regfile
  import pot_pkg::*;
#(
  parameter int          N_POT   = 4,
  parameter int          W       = 6,
  parameter logic [W-1:0] R0_INIT = W'(32)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  cmd_t               cmd_i,
  input  logic [W-1:0]       wdata_i,
  output logic [N_POT*W-1:0] wiper_o,
  output logic [W-1:0]       rd_w_o,
  output logic [W-1:0]       rd_d_o
);
  localparam logic [W-1:0] WMAX = {W{1'b1}};

  logic [W-1:0] wv [N_POT];
  logic [W-1:0] dv [N_POT];

  for (genvar p = 0; p < N_POT; p++) begin : g_pot
    logic [W-1:0] wiper_q;
    logic [W-1:0] dreg_q [N_DREG];
    logic         sel;

    assign sel = (int'(cmd_i.pot) == p);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wiper_q <= '0;
      end else if (init_i) begin
        wiper_q <= dreg_q[0];
      end else if (cmd_i.wr_w && sel) begin
        wiper_q <= wdata_i;
      end else if (cmd_i.step && sel) begin
        if (cmd_i.up) wiper_q <= (wiper_q == WMAX) ? wiper_q : wiper_q + 1'b1;
        else          wiper_q <= (wiper_q == '0)   ? wiper_q : wiper_q - 1'b1;
      end else if (cmd_i.d2w && (sel || cmd_i.all)) begin
        wiper_q <= dreg_q[cmd_i.rsel];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < N_DREG; r++) dreg_q[r] <= (r == 0) ? R0_INIT : '0;
      end else if (cmd_i.wr_d && sel) begin
        dreg_q[cmd_i.rsel] <= wdata_i;
      end else if (cmd_i.w2d && (sel || cmd_i.all)) begin
        dreg_q[cmd_i.rsel] <= wiper_q;
      end
    end

    assign wv[p] = wiper_q;
    assign dv[p] = dreg_q[cmd_i.rsel];
    assign wiper_o[p*W +: W] = wiper_q;
  end

  assign rd_w_o = wv[cmd_i.pot];
  assign rd_d_o = dv[cmd_i.pot];
endmodule

// File: rtl/pot_cmd_proc.sv
module pot_cmd_proc
  import pot_pkg::*;
#(
  parameter int               N_POT       = 4,
  parameter int               WIPER_W     = 6,
  parameter int               BUSY_CYCLES = 20,
  parameter logic [3:0]       DEV_TYPE    = 4'b0101,
  parameter logic [WIPER_W-1:0] R0_INIT   = WIPER_W'(32)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     byte_valid_i,
  input  logic [7:0]               byte_i,
  input  logic [3:0]               addr_pins_i,
  output logic                     ack_o,
  output logic [7:0]               rd_data_o,
  output logic                     busy_o,
  output logic [N_POT*WIPER_W-1:0] wiper_o
);
  localparam int PAD = 8 - WIPER_W;

  st_e  st_q, st_d;
  op_e  op_q, op_b;
  logic [1:0] pot_q, rsel_q;
  logic ack_q, ack_d;
  logic [7:0] rd_q, rd_next;
  logic rd_load, go_busy, init_q, is_status;
  cmd_t cmd;
  logic [WIPER_W-1:0] rd_w, rd_d;

  assign op_b      = op_e'(byte_i[7:5]);
  assign is_status = (op_b == OP_STEP) && byte_i[0];

  always_comb begin
    st_d    = st_q;
    ack_d   = 1'b0;
    cmd     = '0;
    rd_load = 1'b0;
    go_busy = 1'b0;
    if (start_i) begin
      st_d = ST_ADDR;
    end else if (stop_i) begin
      st_d = ST_IDLE;
    end else if (byte_valid_i) begin
      unique case (st_q)
        ST_ADDR: begin
          if (byte_i[7:4] == DEV_TYPE && byte_i[3:0] == addr_pins_i) begin
            ack_d = 1'b1;
            st_d  = ST_INSTR;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_INSTR: begin
          st_d     = ST_IDLE;
          cmd.pot  = byte_i[2:1];
          cmd.rsel = byte_i[4:3];
          if (int'(byte_i[2:1]) < N_POT && (!busy_o || is_status)) begin
            ack_d = 1'b1;
            unique case (op_b)
              OP_STEP:   if (byte_i[0]) rd_load = 1'b1; else st_d = ST_DATA;
              OP_WR_W,
              OP_WR_D:   st_d = ST_DATA;
              OP_RD_W,
              OP_RD_D:   rd_load = 1'b1;
              OP_D2W:    begin cmd.d2w = 1'b1; go_busy = 1'b1; end
              OP_W2D:    begin cmd.w2d = 1'b1; go_busy = 1'b1; end
              OP_GLOBAL: begin
                cmd.all = 1'b1;
                cmd.w2d = byte_i[0];
                cmd.d2w = !byte_i[0];
                go_busy = 1'b1;
              end
            endcase
          end
        end
        ST_DATA: begin
          cmd.pot  = pot_q;
          cmd.rsel = rsel_q;
          ack_d    = 1'b1;
          st_d     = ST_IDLE;
          unique case (op_q)
            OP_WR_W: cmd.wr_w = 1'b1;
            OP_WR_D: begin cmd.wr_d = 1'b1; go_busy = 1'b1; end
            OP_STEP: begin cmd.step = 1'b1; cmd.up = byte_i[7]; st_d = ST_DATA; end
            default: ack_d = 1'b0;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (is_status)         rd_next = {7'b0, busy_o};
    else if (op_b == OP_RD_W) rd_next = {{PAD{1'b0}}, rd_w};
    else                   rd_next = {{PAD{1'b0}}, rd_d};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_STEP;
      pot_q  <= '0;
      rsel_q <= '0;
      ack_q  <= 1'b0;
      rd_q   <= '0;
      init_q <= 1'b1;
    end else begin
      init_q <= 1'b0;
      st_q   <= st_d;
      ack_q  <= ack_d;
      if (rd_load) rd_q <= rd_next;
      if (st_q == ST_INSTR && byte_valid_i && !start_i && !stop_i) begin
        op_q   <= op_b;
        pot_q  <= byte_i[2:1];
        rsel_q <= byte_i[4:3];
      end
    end
  end

  pot_regfile #(.N_POT(N_POT), .W(WIPER_W), .R0_INIT(R0_INIT)) u_regs (
    .clk_i, .rst_ni, .init_i(init_q), .cmd_i(cmd), .wdata_i(byte_i[WIPER_W-1:0]),
    .wiper_o, .rd_w_o(rd_w), .rd_d_o(rd_d)
  );

  pot_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni, .start_i(go_busy), .busy_o
  );

  assign ack_o     = ack_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/pot_cmd_chk.sv
module pot_cmd_chk
  import pot_pkg::*;
#(
  parameter int N_POT       = 4,
  parameter int WIPER_W     = 6,
  parameter int BUSY_CYCLES = 20
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     byte_valid_i,
  input logic [7:0]               byte_i,
  input logic                     ack_o,
  input logic                     busy_o,
  input logic [N_POT*WIPER_W-1:0] wiper_o,
  input st_e                      st_q,
  input logic                     init_q,
  input cmd_t                     cmd
);
  localparam logic [WIPER_W-1:0] WMAX = {WIPER_W{1'b1}};
  int busy_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  assert_ack_follows_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(byte_valid_i));

  assert_busy_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(busy_o) && $past(st_q) == ST_INSTR) |->
      ($past(byte_i[7:5]) == 3'b000 && $past(byte_i[0])));

  assert_wiper_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(byte_valid_i) && !$past(init_q)) |-> $stable(wiper_o));

  assert_busy_span_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_run == BUSY_CYCLES);

  always_comb begin
    if (rst_ni) assert_busy_bound_R10: assert (busy_run <= BUSY_CYCLES);
  end

  for (genvar p = 0; p < N_POT; p++) begin : g_sat
    assert_sat_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cmd.step) && $past(cmd.up) && int'($past(cmd.pot)) == p &&
       $past(wiper_o[p*WIPER_W +: WIPER_W]) == WMAX) |->
        wiper_o[p*WIPER_W +: WIPER_W] == WMAX);
    assert_sat_bottom_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cmd.step) && !$past(cmd.up) && int'($past(cmd.pot)) == p &&
       $past(wiper_o[p*WIPER_W +: WIPER_W]) == '0) |->
        wiper_o[p*WIPER_W +: WIPER_W] == '0);
  end
endmodule

bind pot_cmd_proc pot_cmd_chk #(
  .N_POT(N_POT), .WIPER_W(WIPER_W), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (.*);

// File: tb/tb_pot_cmd_proc.sv
module tb_pot_cmd_proc;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 20;
  localparam int NP = 4;
  localparam int WW = 6;
  localparam logic [7:0] ADDR_OK = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, bv = 1'b0;
  logic [7:0] bdata = '0;
  logic [3:0] pins = 4'hA;
  logic ack, busy;
  logic [7:0] rd;
  logic [NP*WW-1:0] wip;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pot_cmd_proc #(.N_POT(NP), .WIPER_W(WW), .BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_valid_i(bv), .byte_i(bdata), .addr_pins_i(pins),
    .ack_o(ack), .rd_data_o(rd), .busy_o(busy), .wiper_o(wip)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wp(input int p);
    return int'(wip[p*WW +: WW]);
  endfunction

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic a);
    @(negedge clk); bdata = b; bv = 1'b1;
    @(negedge clk); bv = 1'b0; a = ack;
  endtask

  task automatic wait_idle();
    repeat (BUSY + 2) @(negedge clk);
  endtask

  task automatic write_wiper(input int p, input int v);
    logic a;
    do_start();
    send(ADDR_OK, a);
    send(8'hA0 | 8'(p << 1), a);
    send(8'(v), a);
    do_stop();
  endtask

  task automatic t_reset();
    chk("R11 wiper in reset", wp(2), 0);
    chk("R11 busy in reset", int'(busy), 0);
    chk("R11 ack in reset", int'(ack), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < NP; p++) chk("R11 power-up load", wp(p), 32);
  endtask

  task automatic t_addr();
    logic a;
    pins = 4'hA;
    do_start();
    send(8'h53, a); chk("R1 pin mismatch nack", int'(a), 0);
    send(8'hA4, a); chk("R1 ignored after mismatch", int'(a), 0);
    send(8'h00, a); chk("R1 ignored data", int'(a), 0);
    chk("R1 wiper untouched", wp(2), 32);
    do_start();
    send(8'h6A, a); chk("R1 type mismatch nack", int'(a), 0);
    do_stop();
  endtask

  task automatic t_wiper_write();
    logic a;
    do_start();
    send(ADDR_OK, a); chk("R1 address ack", int'(a), 1);
    send(8'hA4, a);   chk("R2 instruction ack", int'(a), 1);
    send(8'h2D, a);   chk("R3 data ack", int'(a), 1);
    chk("R3 wiper2 written", wp(2), 45);
    chk("R3 wiper1 untouched", wp(1), 32);
    send(8'h11, a);   chk("R3 extra byte nack", int'(a), 0);
    chk("R3 wiper2 held", wp(2), 45);
    do_stop();
  endtask

  task automatic t_wiper_read();
    logic a;
    do_start(); send(ADDR_OK, a); send(8'h84, a);
    chk("R4 read ack", int'(a), 1);
    chk("R4 read wiper2", int'(rd), 45);
    do_start(); send(ADDR_OK, a); send(8'h80, a);
    chk("R4 read wiper0", int'(rd), 32);
    do_stop();
  endtask

  task automatic t_data_busy();
    logic a;
    do_start(); send(ADDR_OK, a); send(8'hFA, a); send(8'h11, a);
    chk("R5 data write ack", int'(a), 1);
    chk("R10 busy after write", int'(busy), 1);
    chk("R5 wiper1 unchanged", wp(1), 32);
    do_start(); send(ADDR_OK, a);
    chk("R10 address ack while busy", int'(a), 1);
    send(8'h01, a);
    chk("R9 status ack while busy", int'(a), 1);
    chk("R9 status busy", int'(rd), 1);
    do_start(); send(ADDR_OK, a); send(8'hDA, a);
    chk("R10 read nack while busy", int'(a), 0);
    do_start(); send(ADDR_OK, a); send(8'hA0, a);
    chk("R10 wiper write nack while busy", int'(a), 0);
    send(8'h07, a);
    chk("R10 no effect while busy", wp(0), 32);
    do_stop();
    wait_idle();
    do_start(); send(ADDR_OK, a); send(8'h01, a);
    chk("R9 status idle", int'(rd), 0);
    do_start(); send(ADDR_OK, a); send(8'hDA, a);
    chk("R5 read data ack", int'(a), 1);
    chk("R5 read pot1 reg3", int'(rd), 17);
    do_stop();
  endtask

  task automatic t_transfer();
    logic a;
    int n;
    do_start(); send(ADDR_OK, a); send(8'h5A, a);
    chk("R6 d2w ack", int'(a), 1);
    chk("R6 wiper1 from reg3", wp(1), 17);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk("R10 busy length", n, BUSY);
    do_stop();
    do_start(); send(ADDR_OK, a); send(8'h74, a);
    chk("R6 w2d ack", int'(a), 1);
    do_stop(); wait_idle();
    do_start(); send(ADDR_OK, a); send(8'hD4, a);
    chk("R6 pot2 reg2 from wiper", int'(rd), 45);
    do_stop();
  endtask

  task automatic t_global();
    logic a;
    do_start(); send(ADDR_OK, a); send(8'h29, a);
    chk("R7 global w2d ack", int'(a), 1);
    do_stop(); wait_idle();
    write_wiper(0, 5);
    write_wiper(3, 9);
    chk("R7 wiper0 scratch", wp(0), 5);
    do_start(); send(ADDR_OK, a); send(8'h28, a);
    chk("R7 global d2w ack", int'(a), 1);
    chk("R7 wiper0 restored", wp(0), 32);
    chk("R7 wiper1 restored", wp(1), 17);
    chk("R7 wiper2 restored", wp(2), 45);
    chk("R7 wiper3 restored", wp(3), 32);
    do_stop(); wait_idle();
  endtask

  task automatic t_step();
    logic a;
    do_start(); send(ADDR_OK, a); send(8'h06, a);
    chk("R8 step cmd ack", int'(a), 1);
    for (int i = 0; i < 3; i++) begin
      send(8'h80, a); chk("R8 step up ack", int'(a), 1);
    end
    chk("R8 three ups", wp(3), 35);
    send(8'h00, a); chk("R8 one down", wp(3), 34);
    do_stop();
    write_wiper(3, 62);
    do_start(); send(ADDR_OK, a); send(8'h06, a);
    for (int i = 0; i < 3; i++) send(8'h80, a);
    chk("R8 saturate at 63", wp(3), 63);
    do_stop();
    write_wiper(3, 1);
    do_start(); send(ADDR_OK, a); send(8'h06, a);
    for (int i = 0; i < 3; i++) send(8'h7F, a);
    chk("R8 saturate at 0", wp(3), 0);
    chk("R8 other wiper untouched", wp(2), 45);
    do_stop();
  endtask

  task automatic t_stop();
    logic a;
    do_start(); send(ADDR_OK, a);
    do_stop();
    send(8'hA0, a); chk("R12 byte after stop nack", int'(a), 0);
    send(ADDR_OK, a); chk("R12 address without start nack", int'(a), 0);
    chk("R12 wiper0 unchanged", wp(0), 32);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_addr();
    t_wiper_write();
    t_wiper_read();
    t_data_busy();
    t_transfer();
    t_global();
    t_step();
    t_stop();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule